// File: doc/BRIEF.md
# Count-Compare Gray-Shade Sequencer

This block is the digital core of an amplitude-modulated display column driver. It keeps one 7-bit shade code per output channel, in two stages. A first bank of code registers is written one channel at a time. A second bank, the compare bank, drives the conversion. A load-count control pulse moves the whole first bank into the compare bank on its leading edge and clears every channel's ramp-gating signal. The trailing edge of the same pulse starts a conversion.

During a conversion, a single shared counter steps once per count-clock pulse, from 0 up to 127. Every channel holds a set/reset flag. While the flag is high, the channel's analog stage follows the external ramp. The flag drops on the step at which the shared count equals the channel's compare code, which freezes the sampled ramp voltage. Code 0 gives the lowest shade and never tracks. Code 127 tracks for the whole count. The first code bank may be rewritten while a conversion runs, so the next frame can load in the background.

The load-count and count-clock inputs may be asynchronous. Each one passes through a two-stage synchronizer followed by an edge detector.

Top module: `gsc_seq`

## Requirements
- R1: After reset, `track_o` is all zero, `count_o` is 0 and `done_o` is 0.
- R2: A cycle with `wr_en` high stores `wr_code` as the pending code of channel `wr_idx`. Pending codes do not affect a conversion in progress. They are used only after the next load-count rising edge.
- R3: On a rising edge of `lc_i`, the pending code of every channel is copied to that channel's compare code. In the same step, every bit of `track_o` is cleared, `count_o` returns to 0 and `done_o` is cleared.
- R4: On a falling edge of `lc_i`, a conversion starts with `count_o` = 0. `track_o[i]` goes high exactly when channel i's compare code is nonzero.
- R5: While a conversion runs, each rising edge of `cc_i` adds exactly one to `count_o`. Count-clock edges have no effect on `count_o` when no conversion is running: while `lc_i` is high, before a start, and after done.
- R6: `track_o[i]` stays high while `count_o` is below channel i's code. It falls on the step at which `count_o` becomes equal to that code, and it stays low until the next load-count pulse. At every point of a conversion, `track_o[i]` = (code > `count_o`).
- R7: When `count_o` reaches 127, `done_o` goes high and the counter stops at 127. Further count-clock edges neither wrap the counter nor clear `done_o`.
- R8: An edge on `lc_i` or `cc_i`, applied just after a clock edge, changes the outputs at the third rising clock edge after it and not before. Each level of these inputs must be held for at least two clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for a pending code |
| wr_idx | input | 5 | Channel index of the pending-code write |
| wr_code | input | 7 | Shade code to store |
| lc_i | input | 1 | Load-count control pulse, asynchronous |
| cc_i | input | 1 | Count clock, asynchronous |
| track_o | output | 32 | Per-channel ramp-tracking enable |
| count_o | output | 7 | Shared conversion count |
| done_o | output | 1 | Conversion has reached the top count |

## Verification
The assertions assume that both control inputs pass through the synchronizers as clean levels. Each high and low phase must last long enough for the edge detector to see exactly one edge. The count clock must only matter once the start has taken effect. The bench holds every load-count and count-clock level for three clock cycles, and it waits four cycles after each load-count edge before it pulses the count clock. This mirrors the rule that counting begins only after the ramp has started. Code writes are issued one per cycle at any time, including in the middle of a conversion, to show that they stay isolated from the running compare.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;
endpackage

// File: rtl/gsc_sync.sv
module gsc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] lvl_d_o
);
  logic [W-1:0] meta_q, lvl_q, lvl_dq;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      lvl_q  <= '0;
      lvl_dq <= '0;
    end else begin
      meta_q <= async_i;
      lvl_q  <= meta_q;
      lvl_dq <= lvl_q;
    end
  end

  assign lvl_o   = lvl_q;
  assign lvl_d_o = lvl_dq;
endmodule

// File: rtl/gsc_counter.sv
module gsc_counter
  import gsc_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfer_i,
  input  logic          start_i,
  input  logic          ccp_i,
  output logic          step_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nx_o,
  output logic          done_o
);
  localparam logic [CW-1:0] TOP = {CW{1'b1}};

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;

  assign step_o   = (ph_q == PH_RUN) && ccp_i;
  assign cnt_nx_o = cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= PH_IDLE;
    end else if (xfer_i) begin
      cnt_q <= '0;
      ph_q  <= PH_IDLE;
    end else if (start_i) begin
      cnt_q <= '0;
      ph_q  <= PH_RUN;
    end else if (step_o) begin
      cnt_q <= cnt_nx_o;
      if (cnt_nx_o == TOP) ph_q <= PH_DONE;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = (ph_q == PH_DONE);

  // R5: one increment per accepted count-clock edge
  a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    (step_o && !xfer_i && !start_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R5: count holds when no edge is accepted
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!step_o && !xfer_i && !start_i) |=> $stable(cnt_q));
  // R7: finished conversion stays at the top count
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (done_o && !xfer_i && !start_i) |=> (done_o && cnt_q == TOP));
endmodule

// File: rtl/gsc_channel.sv
module gsc_channel #(
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_hit_i,
  input  logic [CW-1:0] wr_code_i,
  input  logic          xfer_i,
  input  logic          start_i,
  input  logic          step_i,
  input  logic [CW-1:0] cnt_nx_i,
  output logic          track_o
);
  logic [CW-1:0] pend_q, cmp_q;
  logic          flag_q;
  logic          hit;

  assign hit = step_i && (cnt_nx_i == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else if (wr_hit_i) pend_q <= wr_code_i;
  end

  always_ff @(posedge clk) begin
    if (rst) cmp_q <= '0;
    else if (xfer_i) cmp_q <= pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else if (xfer_i) flag_q <= 1'b0;
    else if (start_i) flag_q <= (cmp_q != '0);
    else if (hit) flag_q <= 1'b0;
  end

  assign track_o = flag_q;

  // R2: compare code only moves on a transfer
  a_r2_cmp_stable: assert property (@(posedge clk) disable iff (rst)
    !xfer_i |=> $stable(cmp_q));
  // R3: transfer clears the tracking flag
  a_r3_clear_on_xfer: assert property (@(posedge clk) disable iff (rst)
    xfer_i |=> !flag_q);
  // R6: flag only drops on a matching step
  a_r6_hold_until_match: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !xfer_i && !start_i && !hit) |=> flag_q);
  // R6: a matching step ends tracking
  a_r6_drop_on_match: assert property (@(posedge clk) disable iff (rst)
    (flag_q && hit && !xfer_i) |=> !flag_q);
endmodule

// File: rtl/gsc_seq.sv
module gsc_seq #(
  parameter int NCH = 32,
  parameter int CW  = 7,
  parameter int IW  = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [CW-1:0]  wr_code,
  input  logic           lc_i,
  input  logic           cc_i,
  output logic [NCH-1:0] track_o,
  output logic [CW-1:0]  count_o,
  output logic           done_o
);
  localparam int LC_B = 0;
  localparam int CC_B = 1;

  logic [1:0]    lvl, lvl_d;
  logic          xfer, start, ccp, step;
  logic [CW-1:0] cnt_nx;

  gsc_sync #(.W(2)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({cc_i, lc_i}),
    .lvl_o   (lvl),
    .lvl_d_o (lvl_d)
  );

  assign xfer  = lvl[LC_B] && !lvl_d[LC_B];
  assign start = !lvl[LC_B] && lvl_d[LC_B];
  assign ccp   = lvl[CC_B] && !lvl_d[CC_B];

  gsc_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .xfer_i   (xfer),
    .start_i  (start),
    .ccp_i    (ccp),
    .step_o   (step),
    .cnt_o    (count_o),
    .cnt_nx_o (cnt_nx),
    .done_o   (done_o)
  );

  for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
    gsc_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst       (rst),
      .wr_hit_i  (wr_en && (wr_idx == IW'(gi))),
      .wr_code_i (wr_code),
      .xfer_i    (xfer),
      .start_i   (start),
      .step_i    (step),
      .cnt_nx_i  (cnt_nx),
      .track_o   (track_o[gi])
    );
  end

  // R8: each load-count edge yields a single-cycle transfer
  a_r8_xfer_once: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);
  // R3: after a transfer no channel tracks
  a_r3_all_clear: assert property (@(posedge clk) disable iff (rst)
    xfer |=> (track_o == '0 && count_o == '0 && !done_o));
  // R7: nothing tracks once the conversion is complete
  a_r7_done_idle: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (track_o == '0));
endmodule

// File: tb/tb_gsc_seq.sv
module tb_gsc_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 32;
  localparam int CW  = 7;

  logic clk = 0, rst = 1, wr_en = 0, lc_i = 0, cc_i = 0;
  logic [4:0] wr_idx = '0;
  logic [CW-1:0] wr_code = '0;
  logic [NCH-1:0] track_o;
  logic [CW-1:0] count_o;
  logic done_o;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gsc_seq dut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
               .wr_code(wr_code), .lc_i(lc_i), .cc_i(cc_i),
               .track_o(track_o), .count_o(count_o), .done_o(done_o));

  function automatic logic [CW-1:0] code_of(int pat, int i);
    if (pat == 0) begin
      if (i == 0) return 7'd0;
      if (i == 31) return 7'd127;
      return CW'((i * 4 + 1) % 128);
    end
    return CW'(127 - 4 * i);
  endfunction

  function automatic logic [NCH-1:0] mask_of(int pat, int cnt);
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = (int'(code_of(pat, i)) > cnt);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_pat(input int pat);
    for (int i = 0; i < NCH; i++) begin
      wr_en = 1; wr_idx = 5'(i); wr_code = code_of(pat, i);
      cyc(1);
    end
    wr_en = 0;
  endtask

  task automatic cc_pulse();
    cc_i = 1; cyc(3);
    cc_i = 0; cyc(3);
  endtask

  task automatic t_reset();
    chk(track_o == '0, "R1 track", track_o, 0);
    chk(count_o == '0, "R1 count", count_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
  endtask

  task automatic t_load_start(input int pat);
    lc_i = 1; cyc(4);
    chk(track_o == '0, "R3 track cleared", track_o, 0);
    chk(count_o == '0 && !done_o, "R3 count/done cleared", {done_o, count_o}, 0);
    cc_pulse();
    chk(count_o == '0, "R5 cc ignored during load", count_o, 0);
    lc_i = 0; cyc(4);
    chk(track_o == mask_of(pat, 0), "R4 start mask", track_o, mask_of(pat, 0));
    chk(count_o == '0, "R4 start count", count_o, 0);
  endtask

  task automatic t_steps(input int pat, input int from, input int to, input int repat);
    for (int k = from; k <= to; k++) begin
      cc_pulse();
      chk(count_o == CW'(k), "R5 step count", count_o, k);
      chk(track_o == mask_of(pat, k), "R6 track mask", track_o, mask_of(pat, k));
      if (k == 126) chk(track_o[31] == (code_of(pat, 31) == 7'd127), "R6 full-code channel",
                        track_o[31], code_of(pat, 31) == 7'd127);
      if (k == 10 && repat >= 0) begin
        write_pat(repat);
        chk(track_o == mask_of(pat, k), "R2 rewrite isolated", track_o, mask_of(pat, k));
      end
    end
  endtask

  task automatic t_done();
    chk(done_o == 1'b1 && count_o == 7'd127, "R7 done at top", {done_o, count_o}, 8'hFF);
    cc_pulse(); cc_pulse();
    chk(count_o == 7'd127, "R7 no wrap", count_o, 127);
    chk(done_o == 1'b1, "R5 cc ignored after done", done_o, 1);
  endtask

  task automatic t_timing(input int pat, input int cnt);
    lc_i = 1; cyc(2);
    chk(track_o == mask_of(pat, cnt), "R8 no early effect", track_o, mask_of(pat, cnt));
    cyc(1);
    chk(track_o == '0 && count_o == '0, "R8 effect at third edge", track_o, 0);
    cyc(2);
    lc_i = 0; cyc(4);
    chk(track_o == mask_of(pat, 0), "R4 restart mask", track_o, mask_of(pat, 0));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog R5 actual=hung expected=finished");
    finish_run();
  end

  initial begin
    cyc(3); rst = 0; cyc(1);
    t_reset();
    write_pat(0);
    t_load_start(0);
    t_steps(0, 1, 127, 1);
    t_done();
    t_load_start(1);
    chk(done_o == 1'b0, "R3 done cleared by load", done_o, 0);
    t_steps(1, 1, 20, -1);
    t_timing(1, 20);
    t_steps(1, 1, 127, -1);
    t_done();
    finish_run();
  end
endmodule